// File: doc/BRIEF.md
# Half-Duplex MII Transmit Sequencer with Collision Retry

This block turns one stored frame into a nibble stream on an MII-style transmit pair (4-bit data plus enable), one nibble per transmit clock. It sends a preamble and start delimiter first. It then sends the payload bytes and, when enabled, zero padding up to the minimum size and a CRC-32 check sequence. The payload is read through a byte-address port: the block presents an index, and the source returns that byte along with a marker for the final byte. Because each attempt starts again from index 0, a frame can be replayed after a collision without the block holding a copy of it.

In half-duplex mode the block waits for the medium to be quiet before it transmits. On a collision it sends a jam pattern and stops. It then waits a random number of slot times, drawn from a window that doubles with each collision up to a cap, and tries again. After a set number of collisions it gives up and raises an abort pulse. In full-duplex mode it ignores carrier and collision and only keeps the interframe gap. A done pulse marks each frame that was sent in full.

Top module: `mii_csma_tx`

## Requirements
- R1: After reset, tx_en_o, done_o and abort_o are all low and no nibble is driven until start_i is seen.
- R2: Each attempt opens with 16 nibbles: fifteen of value 0x5 followed by one of value 0xD. This is seven 0x55 bytes and a 0xD5 delimiter, each sent low nibble first.
- R3: After the delimiter, payload bytes are sent in index order from 0 up to the byte flagged by byte_last_i, low nibble first. byte_addr_o holds the index of the byte being sent.
- R4: With pad_en_i high, a payload shorter than MIN_LEN (60) bytes is followed by zero bytes up to MIN_LEN. With pad_en_i low, or with a payload of MIN_LEN bytes or more, no padding is added.
- R5: With fcs_en_i high, the padded payload is followed by 8 nibbles holding the complemented reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) of payload plus padding, least significant nibble first. With fcs_en_i low, nothing is sent after the payload or padding.
- R6: In half-duplex mode (full_dup_i low), the first preamble nibble appears only after crs_i has been low for IFG_CYC (24) consecutive cycles, which is 96 bit times. Any cycle with crs_i high restarts that count.
- R7: In half-duplex mode, collision seen in a transmit cycle switches the output, from the next cycle, to JAM_CYC (8) cycles of nibble 0xA, after which tx_en_o falls.
- R8: After the n-th collision of a frame, the number of idle cycles between the end of the jam and the next preamble is 1 + r·SLOT_CYC + IFG_CYC, with r in [0, 2^min(n,10) − 1]. The retry then resends the whole frame.
- R9: The MAX_ATTEMPTS-th (16th) collision of a frame ends it: abort_o pulses for one cycle, done_o does not pulse, and the frame is not transmitted again.
- R10: In full-duplex mode, crs_i and col_i have no effect. The frame is sent complete, no jam occurs, and the first nibble appears IFG_CYC+1 cycles after start_i is sampled.
- R11: done_o pulses for one cycle in the cycle right after the last nibble of a frame that completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit nibble clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that requests transmission of the frame |
| full_dup_i | input | 1 | 1 selects full duplex, 0 selects half duplex |
| pad_en_i | input | 1 | Enables padding to the minimum size |
| fcs_en_i | input | 1 | Enables appending the CRC-32 check sequence |
| byte_addr_o | output | ADDR_W | Index of the payload byte being sent |
| byte_i | input | 8 | Payload byte at byte_addr_o |
| byte_last_i | input | 1 | High when byte_addr_o is the final payload byte |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detect |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |
| done_o | output | 1 | One-cycle pulse when a frame has been sent in full |
| abort_o | output | 1 | One-cycle pulse when the retry limit has been reached |

## Verification
Some rules can be judged cycle by cycle, and the assertions check them continuously:
- every burst starts with a preamble nibble;
- in half-duplex mode a transmission never starts right after a cycle with carrier;
- a collision during transmission leads to jam in the next cycle;
- full-duplex operation never enters jam;
- done_o and abort_o appear only after the end of a burst, and never together.

Other properties only show over a whole burst or a whole frame sequence, so only the bench scenarios can confirm them:
- the nibble content, padding length and CRC value;
- the exact length of the deferral gap;
- the slot-multiple backoff window that widens with each collision;
- the abort after the sixteenth collision.

// File: rtl/mii_csma_tx_pkg.sv
package mii_csma_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEFER, ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_JAM, ST_BACKOFF
  } tx_state_e;

  localparam logic [3:0]  PRE_NIB  = 4'h5;
  localparam logic [3:0]  SFD_NIB  = 4'hD;
  localparam logic [3:0]  JAM_NIB  = 4'hA;
  localparam int unsigned PRE_NIBS = 16;
  localparam int unsigned FCS_NIBS = 8;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/mii_csma_tx_crc.sv
module mii_csma_tx_crc
  import mii_csma_tx_pkg::*;
(
  input  logic [31:0] crc_i,
  input  logic [3:0]  nib_i,
  output logic [31:0] crc_o
);
  logic [31:0] c;

  // reflected CRC-32, one nibble per call, lsb first
  always_comb begin
    c = crc_i;
    for (int i = 0; i < 4; i++) begin
      c = (c[0] ^ nib_i[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/mii_csma_tx_lfsr.sv
module mii_csma_tx_lfsr #(
  parameter int unsigned W     = 16,
  parameter int unsigned OUT_W = 10,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/mii_csma_tx.sv
module mii_csma_tx
  import mii_csma_tx_pkg::*;
#(
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned MIN_LEN       = 60,
  parameter int unsigned IFG_CYC       = 24,
  parameter int unsigned SLOT_CYC      = 128,
  parameter int unsigned JAM_CYC       = 8,
  parameter int unsigned MAX_ATTEMPTS  = 16,
  parameter int unsigned BACKOFF_LIMIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              full_dup_i,
  input  logic              pad_en_i,
  input  logic              fcs_en_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  input  logic [7:0]        byte_i,
  input  logic              byte_last_i,
  input  logic              crs_i,
  input  logic              col_i,
  output logic [3:0]        txd_o,
  output logic              tx_en_o,
  output logic              done_o,
  output logic              abort_o
);
  localparam int unsigned M1      = (IFG_CYC > SLOT_CYC) ? IFG_CYC : SLOT_CYC;
  localparam int unsigned M2      = (M1 > JAM_CYC) ? M1 : JAM_CYC;
  localparam int unsigned CNT_MAX = (M2 > PRE_NIBS) ? M2 : PRE_NIBS;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned BO_W    = BACKOFF_LIMIT;

  localparam logic [CNT_W-1:0]  IFG_LAST  = CNT_W'(IFG_CYC - 1);
  localparam logic [CNT_W-1:0]  SLOT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0]  JAM_LAST  = CNT_W'(JAM_CYC - 1);
  localparam logic [CNT_W-1:0]  PRE_LAST  = CNT_W'(PRE_NIBS - 1);
  localparam logic [CNT_W-1:0]  FCS_LAST  = CNT_W'(FCS_NIBS - 1);
  localparam logic [ATT_W-1:0]  ATT_LAST  = ATT_W'(MAX_ATTEMPTS - 1);
  localparam logic [ADDR_W:0]   MIN_LEN_W = (ADDR_W + 1)'(MIN_LEN);
  localparam logic [ADDR_W-1:0] PAD_LAST  = ADDR_W'(MIN_LEN - 1);

  tx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               nib_q, nib_d;
  logic [ADDR_W-1:0]  byte_cnt_q, byte_cnt_d;
  logic [31:0]        crc_q, crc_d, crc_upd;
  logic [ATT_W-1:0]   att_q, att_d;
  logic [BO_W-1:0]    bo_q, bo_d;
  logic               done_q, done_d, abort_q, abort_d;

  logic               half, col_hit, short_after;
  logic [3:0]         nib_out;
  logic [ATT_W-1:0]   n_coll;
  logic [BO_W:0]      bo_span;
  logic [BO_W-1:0]    bo_mask, rnd;

  mii_csma_tx_crc u_crc (.crc_i(crc_q), .nib_i(nib_out), .crc_o(crc_upd));

  mii_csma_tx_lfsr #(.OUT_W(BO_W)) u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd));

  assign half        = !full_dup_i;
  assign col_hit     = half && col_i &&
                       (state_q inside {ST_PRE, ST_DATA, ST_PAD, ST_FCS});
  assign short_after = ({1'b0, byte_cnt_q} + 1'b1) < MIN_LEN_W;
  assign n_coll      = att_q + 1'b1;
  assign bo_span     = (n_coll >= ATT_W'(BO_W)) ? {1'b1, {BO_W{1'b0}}}
                                                : ((BO_W + 1)'(1) << n_coll);
  assign bo_mask     = BO_W'(bo_span - 1'b1);

  always_comb begin
    unique case (state_q)
      ST_PRE:  nib_out = (cnt_q == PRE_LAST) ? SFD_NIB : PRE_NIB;
      ST_DATA: nib_out = nib_q ? byte_i[7:4] : byte_i[3:0];
      ST_FCS:  nib_out = ~crc_q[3:0];
      ST_JAM:  nib_out = JAM_NIB;
      default: nib_out = 4'h0;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    nib_d      = nib_q;
    byte_cnt_d = byte_cnt_q;
    crc_d      = crc_q;
    att_d      = att_q;
    bo_d       = bo_q;
    done_d     = 1'b0;
    abort_d    = 1'b0;
    if (col_hit) begin
      state_d = ST_JAM;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_DEFER;
          cnt_d   = '0;
          att_d   = '0;
        end
        ST_DEFER: begin
          crc_d = '1;
          if (half && crs_i) cnt_d = '0;
          else if (cnt_q == IFG_LAST) begin
            state_d = ST_PRE;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_PRE: if (cnt_q == PRE_LAST) begin
          state_d    = ST_DATA;
          nib_d      = 1'b0;
          byte_cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
        ST_DATA, ST_PAD: begin
          crc_d = crc_upd;
          nib_d = ~nib_q;
          if (nib_q) begin
            byte_cnt_d = byte_cnt_q + 1'b1;
            if ((state_q == ST_DATA) && byte_last_i && pad_en_i && short_after) begin
              state_d = ST_PAD;
            end else if ((state_q == ST_DATA) ? byte_last_i : (byte_cnt_q == PAD_LAST)) begin
              cnt_d = '0;
              if (fcs_en_i) state_d = ST_FCS;
              else begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
              end
            end
          end
        end
        ST_FCS: begin
          crc_d = {4'hF, crc_q[31:4]};
          if (cnt_q == FCS_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_JAM: if (cnt_q == JAM_LAST) begin
          cnt_d = '0;
          att_d = n_coll;
          if (att_q == ATT_LAST) begin
            state_d = ST_IDLE;
            abort_d = 1'b1;
          end else begin
            state_d = ST_BACKOFF;
            bo_d    = rnd & bo_mask;
          end
        end else cnt_d = cnt_q + 1'b1;
        ST_BACKOFF: begin
          if (bo_q == '0) begin
            state_d = ST_DEFER;
            cnt_d   = '0;
          end else if (cnt_q == SLOT_LAST) begin
            cnt_d = '0;
            bo_d  = bo_q - 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      nib_q      <= 1'b0;
      byte_cnt_q <= '0;
      crc_q      <= '1;
      att_q      <= '0;
      bo_q       <= '0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      nib_q      <= nib_d;
      byte_cnt_q <= byte_cnt_d;
      crc_q      <= crc_d;
      att_q      <= att_d;
      bo_q       <= bo_d;
      done_q     <= done_d;
      abort_q    <= abort_d;
    end
  end

  assign byte_addr_o = byte_cnt_q;
  assign txd_o       = nib_out;
  assign tx_en_o     = state_q inside {ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_JAM};
  assign done_o      = done_q;
  assign abort_o     = abort_q;
endmodule

// File: rtl/mii_csma_tx_chk.sv
module mii_csma_tx_chk
  import mii_csma_tx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       full_dup_i,
  input logic       crs_i,
  input logic       col_i,
  input logic [3:0] txd_o,
  input logic       tx_en_o,
  input logic       done_o,
  input logic       abort_o,
  input tx_state_e  state_i
);
  p_pre_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> txd_o == PRE_NIB);

  p_defer_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_dup_i && !$past(full_dup_i) && $rose(tx_en_o)) |-> !$past(crs_i));

  p_jam_on_col_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_dup_i && col_i && (state_i inside {ST_PRE, ST_DATA, ST_PAD, ST_FCS}))
    |=> (state_i == ST_JAM && tx_en_o && txd_o == JAM_NIB));

  p_abort_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!tx_en_o && !done_o && $past(tx_en_o)));

  p_fd_no_jam_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_dup_i && state_i != ST_JAM) |=> state_i != ST_JAM);

  p_done_after_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(tx_en_o) && !tx_en_o));
endmodule

bind mii_csma_tx mii_csma_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .full_dup_i(full_dup_i),
  .crs_i     (crs_i),
  .col_i     (col_i),
  .txd_o     (txd_o),
  .tx_en_o   (tx_en_o),
  .done_o    (done_o),
  .abort_o   (abort_o),
  .state_i   (state_q)
);

// File: tb/mii_csma_tx_tb.sv
module mii_csma_tx_tb;
  localparam int IFG   = 24;
  localparam int SLOT  = 4;
  localparam int JAM   = 8;
  localparam int MAXA  = 16;
  localparam int MINL  = 60;

  logic        clk = 1'b0;
  logic        rst_ni, start_i, full_dup_i, pad_en_i, fcs_en_i, crs_i, col_i;
  logic [10:0] byte_addr_o;
  logic [7:0]  byte_i;
  logic        byte_last_i;
  logic [3:0]  txd_o;
  logic        tx_en_o, done_o, abort_o;

  logic [7:0]  mem [0:255];
  int          len_cur;
  logic [3:0]  cap [0:511];
  logic [3:0]  exp_q [0:511];
  int          cap_n, exp_n, done_cnt, abort_cnt;
  logic        prev_en;
  int          checks, fails;
  bit          finished;

  always #5 clk = ~clk;

  assign byte_i      = mem[byte_addr_o[7:0]];
  assign byte_last_i = (int'(byte_addr_o) == len_cur - 1);

  mii_csma_tx #(.SLOT_CYC(SLOT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .full_dup_i(full_dup_i),
    .pad_en_i(pad_en_i), .fcs_en_i(fcs_en_i), .byte_addr_o(byte_addr_o),
    .byte_i(byte_i), .byte_last_i(byte_last_i), .crs_i(crs_i), .col_i(col_i),
    .txd_o(txd_o), .tx_en_o(tx_en_o), .done_o(done_o), .abort_o(abort_o)
  );

  initial begin
    cap_n = 0; done_cnt = 0; abort_cnt = 0; prev_en = 1'b0;
  end

  always @(negedge clk) begin
    if (tx_en_o) begin
      if (!prev_en) cap_n = 0;
      if (cap_n < 512) cap[cap_n] = txd_o;
      cap_n++;
    end
    prev_en = tx_en_o;
    if (done_o) done_cnt++;
    if (abort_o) abort_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic setup(input int len, input bit pad, input bit fcs, input bit full);
    logic [31:0] crc;
    int leff;
    logic [7:0] b;
    len_cur = len; pad_en_i = pad; fcs_en_i = fcs; full_dup_i = full;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + len * 11 + 3) & 255);
    leff = (pad && len < MINL) ? MINL : len;
    exp_n = 0;
    for (int i = 0; i < 15; i++) begin exp_q[exp_n] = 4'h5; exp_n++; end
    exp_q[exp_n] = 4'hD; exp_n++;
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < leff; i++) begin
      b = (i < len) ? mem[i] : 8'h00;
      exp_q[exp_n] = b[3:0]; exp_n++;
      exp_q[exp_n] = b[7:4]; exp_n++;
      for (int k = 0; k < 8; k++)
        crc = ((crc[0] ^ b[k]) != 0) ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
    end
    if (fcs) begin
      crc = ~crc;
      for (int k = 0; k < 8; k++) begin exp_q[exp_n] = crc[4*k +: 4]; exp_n++; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0, input string tag);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11", {tag, " done pulse count"}, done_cnt - d0, 1);
  endtask

  task automatic compare(input bit fcs, input string tag);
    int pre_bad = 0, dat_bad = 0, fcs_bad = 0;
    int dend = fcs ? exp_n - 8 : exp_n;
    for (int i = 0; i < exp_n && i < 512; i++) begin
      if (i >= cap_n || cap[i] !== exp_q[i]) begin
        if (i < 16) pre_bad++;
        else if (i < dend) dat_bad++;
        else fcs_bad++;
      end
    end
    chk(cap_n == exp_n, "R4", {tag, " nibble count"}, cap_n, exp_n);
    chk(pre_bad == 0, "R2", {tag, " preamble mismatches"}, pre_bad, 0);
    chk(dat_bad == 0, "R3", {tag, " payload/pad mismatches"}, dat_bad, 0);
    if (fcs) chk(fcs_bad == 0, "R5", {tag, " fcs mismatches"}, fcs_bad, 0);
  endtask

  task automatic wait_rise(output int gap, output bit ok);
    gap = 0; ok = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (tx_en_o) begin ok = 1; break; end
      gap++;
    end
  endtask

  // col at negedge N; jam visible from N+1 for JAM cycles, then idle
  task automatic inject_col(input int after);
    int bad = 0;
    repeat (after) @(negedge clk);
    col_i = 1'b1;
    @(negedge clk); col_i = 1'b0;
    for (int j = 0; j < JAM; j++) begin
      if (j > 0) @(negedge clk);
      if (!(tx_en_o && txd_o == 4'hA)) bad++;
    end
    chk(bad == 0, "R7", "jam cycles not 0xA", bad, 0);
    @(negedge clk);
    chk(!tx_en_o, "R7", "tx_en after jam", int'(tx_en_o), 0);
  endtask

  task automatic check_gap(input int idle, input int ncoll);
    int r = idle - 1 - IFG;
    int e = (ncoll > 10) ? 10 : ncoll;
    int mask = (1 << e) - 1;
    bit ok = (r >= 0) && (r % SLOT == 0) && (r / SLOT <= mask);
    chk(ok, "R8", $sformatf("backoff idle after collision %0d", ncoll), idle, 1 + IFG);
  endtask

  initial begin
    int lens [7] = '{1, 2, 45, 59, 60, 61, 100};
    int gap, d0, a0, hi, k_rise;
    bit ok;
    checks = 0; fails = 0; finished = 0;
    rst_ni = 1'b0; start_i = 1'b0; full_dup_i = 1'b0; pad_en_i = 1'b0;
    fcs_en_i = 1'b0; crs_i = 1'b0; col_i = 1'b0; len_cur = 1;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_en_o, "R1", "tx_en after reset", int'(tx_en_o), 0);
    chk(!done_o, "R1", "done after reset", int'(done_o), 0);
    chk(!abort_o, "R1", "abort after reset", int'(abort_o), 0);

    // sweep length x pad x fcs, half duplex, quiet medium
    foreach (lens[li]) begin
      for (int p = 0; p < 2; p++) begin
        for (int f = 0; f < 2; f++) begin
          setup(lens[li], p[0], f[0], 1'b0);
          d0 = done_cnt;
          pulse_start();
          wait_done(d0, $sformatf("len%0d pad%0d fcs%0d", lens[li], p, f));
          compare(f[0], $sformatf("len%0d pad%0d fcs%0d", lens[li], p, f));
        end
      end
    end

    // R6 deferral on carrier
    setup(20, 1'b1, 1'b1, 1'b0);
    crs_i = 1'b1;
    d0 = done_cnt;
    pulse_start();
    hi = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (tx_en_o) hi++; end
    chk(hi == 0, "R6", "tx while carrier", hi, 0);
    crs_i = 1'b0;
    k_rise = 0;
    for (int k = 1; k <= IFG + 5; k++) begin
      @(negedge clk);
      if (tx_en_o && k_rise == 0) k_rise = k;
    end
    chk(k_rise == IFG, "R6", "cycles from carrier drop to preamble", k_rise, IFG);
    wait_done(d0, "defer");
    compare(1'b1, "defer");

    // R10 full duplex, carrier and collision held high
    setup(30, 1'b1, 1'b1, 1'b1);
    crs_i = 1'b1; col_i = 1'b1;
    d0 = done_cnt; a0 = abort_cnt;
    @(negedge clk); start_i = 1'b1;
    k_rise = 0;
    for (int k = 1; k <= IFG + 10; k++) begin
      @(negedge clk); start_i = 1'b0;
      if (tx_en_o && k_rise == 0) k_rise = k;
    end
    chk(k_rise == IFG + 1, "R10", "full-duplex start latency", k_rise, IFG + 1);
    wait_done(d0, "full duplex");
    compare(1'b1, "full duplex R10");
    chk(abort_cnt == a0, "R10", "abort in full duplex", abort_cnt - a0, 0);
    crs_i = 1'b0; col_i = 1'b0;

    // R7/R8 one collision then clean retry
    setup(100, 1'b1, 1'b1, 1'b0);
    d0 = done_cnt;
    pulse_start();
    wait_rise(gap, ok);
    chk(ok, "R7", "first attempt start", int'(ok), 1);
    inject_col(20);
    wait_rise(gap, ok);
    chk(ok, "R8", "retry start", int'(ok), 1);
    check_gap(gap + 1, 1);
    wait_done(d0, "retry");
    compare(1'b1, "retry R8");

    // R9 collide on every attempt
    setup(100, 1'b0, 1'b1, 1'b0);
    d0 = done_cnt; a0 = abort_cnt;
    pulse_start();
    for (int a = 1; a <= MAXA; a++) begin
      wait_rise(gap, ok);
      if (!ok) begin
        chk(0, "R9", "attempt did not start", a, MAXA);
        break;
      end
      if (a > 1) check_gap(gap + 1, a - 1);
      inject_col(4);
    end
    for (int i = 0; i < 50 && abort_cnt == a0; i++) @(negedge clk);
    chk(abort_cnt == a0 + 1, "R9", "abort pulses", abort_cnt - a0, 1);
    chk(done_cnt == d0, "R9", "done pulses after abort", done_cnt - d0, 0);
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (tx_en_o) hi++; end
    chk(hi == 0, "R9", "tx after abort", hi, 0);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finish_run();
  end
endmodule